// File: doc/BRIEF.md
# Banked Register File Addresser

This block turns a register-file access from an 8-bit CPU into a physical address for a backing register array. The data memory has two banks. A direct access joins a 7-bit offset from the instruction with a bank-select bit that comes from the status register. When the offset selects the virtual indirect-data location (offset 00h), the block does not use the instruction offset. It uses the full 8-bit pointer register as the logical address, and the bank bit has no effect.

The pointer register is held inside the block. A write to offset 04h loads it, and offset 04h is reachable from either bank. Some core registers sit at the same offset in both banks: program-counter low (02h), status (03h), the pointer (04h) and interrupt control (0Bh). For these, an access with bank bit 1 folds onto the bank-0 copy. The CPU core reads the result on `rdata_o` in the same cycle as the request. A write to the backing array takes effect at the next rising clock edge.

The implemented logical locations are:
- 01h and 81h, a timer register and an option register.
- 05h and 06h, the port data registers.
- 85h and 86h, the matching port direction registers.
- The mirrored offsets listed above.
- Bank-0 general-purpose bytes from 0Ch up to the `GPR_LAST` parameter (default 2Fh).

Every other location reads as zero, and writes to it are dropped.

Top module: `brfa_addresser`

## Requirements
- R1: A direct access (offset not 00h) to an implemented, non-mirrored location drives `mem_addr_o = {bank_sel_i, op_field_i}`. `mem_rd_o` follows `rd_i`, `mem_wr_o` follows `wr_i`, and `mem_wdata_o` carries `wdata_i`.
- R2: Bank bit 0 selects bank 0 and bank bit 1 selects bank 1. Offset 05h gives the port A data register at 05h with bank 0 and the port A direction register at 85h with bank 1. Offset 01h gives 01h with bank 0 and 81h with bank 1.
- R3: Offsets 02h, 03h and 0Bh map to physical 02h, 03h and 0Bh whatever the bank bit. Offset 04h reaches the pointer register from either bank.
- R4: An access at offset 00h uses all 8 bits of the pointer as the logical address and ignores the bank bit.
- R5: A write to offset 04h loads the pointer at the next clock edge and issues no backing-array strobe. A read of offset 04h returns the pointer. An indirect access in the cycle right after the pointer write uses the new value.
- R6: An indirect access whose pointer is 00h or 80h returns zero on a read, drops a write, and drives no backing-array strobe.
- R7: Unimplemented locations return zero and drive no strobe. These are offsets 07h–0Ah in either bank, bank-0 offsets above `GPR_LAST`, and bank-1 offsets 8Ch–FFh. The same holds when such a location is reached through the pointer.
- R8: Mirroring also applies to indirect accesses. Pointer 83h or 8Bh reaches physical 03h or 0Bh, and pointer 84h returns the pointer value itself with no strobe.
- R9: After a synchronous active-low reset the pointer is 00h.
- R10: When neither `rd_i` nor `wr_i` is set, no strobe is driven and `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_field_i | input | 7 | Register offset from the instruction |
| bank_sel_i | input | 1 | Bank-select bit from the status register |
| rd_i | input | 1 | Read request |
| wr_i | input | 1 | Write request |
| wdata_i | input | 8 | Write data from the CPU |
| rdata_o | output | 8 | Read data to the CPU |
| mem_addr_o | output | 8 | Physical address to the backing array |
| mem_rd_o | output | 1 | Backing array read strobe |
| mem_wr_o | output | 1 | Backing array write strobe |
| mem_wdata_o | output | 8 | Backing array write data |
| mem_rdata_i | input | 8 | Backing array read data |

## Verification
The hardest case to reach is an indirect access that lands on a special location: the indirect location itself (pointer 00h or 80h), the pointer register (84h), or a mirrored or unimplemented bank-1 address. To reach it, the stimulus first writes the pointer through offset 04h. It then makes the indirect access in the very next cycle, and finally reads the pointer back through offset 04h to confirm that a dropped write left it unchanged. Unimplemented bank-1 writes are checked by reading the bank-0 location at the same offset, which proves that nothing was folded onto it.

// File: rtl/brfa_pkg.sv
// Shared constants, access classes and the mirrored-offset helper for the
// banked register file addresser. Assumes a 7-bit offset and 8-bit data.
package brfa_pkg;
    localparam int OFF_W  = 7;
    localparam int DATA_W = 8;

    // How a resolved logical address is served
    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,   // unimplemented: read zero, drop writes
        CLS_BACK = 2'd1,   // served by the backing array
        CLS_PTR  = 2'd2,   // served by the internal pointer register
        CLS_SELF = 2'd3    // indirect location pointing at itself
    } acc_class_e;

    localparam logic [OFF_W-1:0] OFF_IND  = 7'h00;
    localparam logic [OFF_W-1:0] OFF_TMR  = 7'h01;
    localparam logic [OFF_W-1:0] OFF_PCL  = 7'h02;
    localparam logic [OFF_W-1:0] OFF_STAT = 7'h03;
    localparam logic [OFF_W-1:0] OFF_PTR  = 7'h04;
    localparam logic [OFF_W-1:0] OFF_PRTA = 7'h05;
    localparam logic [OFF_W-1:0] OFF_PRTB = 7'h06;
    localparam logic [OFF_W-1:0] OFF_ICTL = 7'h0B;
    localparam logic [OFF_W-1:0] OFF_GPR0 = 7'h0C;

    // True for offsets that resolve to bank 0 whatever the bank bit
    function automatic logic is_mirrored(input logic [OFF_W-1:0] off);
        return (off == OFF_IND) || (off == OFF_PCL) || (off == OFF_STAT) ||
               (off == OFF_PTR) || (off == OFF_ICTL);
    endfunction
endpackage

// File: rtl/brfa_addr_mux.sv
// Forms the logical address of an access. A direct access joins the bank bit
// with the instruction offset; offset 00h redirects through the pointer.
// Assumes the pointer is one bit wider than the offset.
module brfa_addr_mux #(
    parameter int OFF_W = brfa_pkg::OFF_W,
    localparam int LA_W = OFF_W + 1
) (
    input  logic [OFF_W-1:0] field_i,
    input  logic             bank_i,
    input  logic [LA_W-1:0]  ptr_i,
    output logic [LA_W-1:0]  la_o,
    output logic             ind_o
);
    // Select between pointer and bank/offset concatenation
    always_comb begin
        ind_o = (field_i == '0);
        la_o  = ind_o ? ptr_i : {bank_i, field_i};
    end
endmodule

// File: rtl/brfa_region_decode.sv
// Classifies a logical address and folds mirrored offsets onto bank 0.
// Assumes general-purpose bytes exist in bank 0 only, from 0Ch to GPR_LAST.
module brfa_region_decode
    import brfa_pkg::*;
#(
    parameter int                OFF_W    = brfa_pkg::OFF_W,
    parameter logic [OFF_W-1:0]  GPR_LAST = 7'h2F,
    localparam int               LA_W     = OFF_W + 1
) (
    input  logic [LA_W-1:0] la_i,
    output acc_class_e      cls_o,
    output logic [LA_W-1:0] phys_o
);
    logic [OFF_W-1:0] off;
    logic             bnk;

    assign off = la_i[OFF_W-1:0];
    assign bnk = la_i[LA_W-1];

    // Decide the serving class and physical address of the location
    always_comb begin
        cls_o  = CLS_NONE;
        phys_o = la_i;
        if (is_mirrored(off)) begin
            phys_o = {1'b0, off};
            if (off == OFF_IND)      cls_o = CLS_SELF;
            else if (off == OFF_PTR) cls_o = CLS_PTR;
            else                     cls_o = CLS_BACK;
        end else if (off == OFF_TMR || off == OFF_PRTA || off == OFF_PRTB) begin
            cls_o = CLS_BACK;
        end else if (!bnk && off >= OFF_GPR0 && off <= GPR_LAST) begin
            cls_o = CLS_BACK;
        end
    end
endmodule

// File: rtl/brfa_ptr_reg.sv
// Holds the 8-bit indirect pointer. Loads on a write enable, clears on a
// synchronous active-low reset. Assumes one write per cycle at most.
module brfa_ptr_reg #(
    parameter int W = brfa_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] ptr_o
);
    // Pointer storage
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr_o <= '0;
        else if (wr_en_i) ptr_o <= wdata_i;
    end

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> ptr_o == $past(wdata_i)); // R5
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(ptr_o)); // R6
    AST_PTR_RESET: assert property (@(posedge clk)
        !rst_n |=> ptr_o == '0); // R9
endmodule

// File: rtl/brfa_addresser.sv
// Top of the banked register file addresser. Resolves direct and indirect
// accesses, routes pointer accesses internally, gates strobes for
// unimplemented or self-referencing locations and returns read data.
// Assumes rd_i and wr_i are not both set and the backing array reads
// combinationally.
module brfa_addresser
    import brfa_pkg::*;
#(
    parameter int               OFF_W    = brfa_pkg::OFF_W,
    parameter logic [OFF_W-1:0] GPR_LAST = 7'h2F,
    localparam int              LA_W     = OFF_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OFF_W-1:0] op_field_i,
    input  logic             bank_sel_i,
    input  logic             rd_i,
    input  logic             wr_i,
    input  logic [LA_W-1:0]  wdata_i,
    output logic [LA_W-1:0]  rdata_o,
    output logic [LA_W-1:0]  mem_addr_o,
    output logic             mem_rd_o,
    output logic             mem_wr_o,
    output logic [LA_W-1:0]  mem_wdata_o,
    input  logic [LA_W-1:0]  mem_rdata_i
);
    logic [LA_W-1:0] ptr_q;
    logic [LA_W-1:0] la;
    logic            ind;
    acc_class_e      cls;
    logic [LA_W-1:0] phys;
    logic            ptr_wr;

    brfa_addr_mux #(.OFF_W(OFF_W)) u_mux (
        .field_i (op_field_i),
        .bank_i  (bank_sel_i),
        .ptr_i   (ptr_q),
        .la_o    (la),
        .ind_o   (ind)
    );

    brfa_region_decode #(.OFF_W(OFF_W), .GPR_LAST(GPR_LAST)) u_dec (
        .la_i   (la),
        .cls_o  (cls),
        .phys_o (phys)
    );

    brfa_ptr_reg #(.W(LA_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (ptr_wr),
        .wdata_i (wdata_i),
        .ptr_o   (ptr_q)
    );

    // Gate strobes by class and route write data
    always_comb begin
        mem_addr_o  = phys;
        mem_wdata_o = wdata_i;
        mem_rd_o    = rd_i && (cls == CLS_BACK);
        mem_wr_o    = wr_i && (cls == CLS_BACK);
        ptr_wr      = wr_i && (cls == CLS_PTR);
    end

    // Select read data for the CPU
    always_comb begin
        rdata_o = '0;
        if (rd_i) begin
            unique case (cls)
                CLS_BACK: rdata_o = mem_rdata_i;
                CLS_PTR:  rdata_o = ptr_q;
                default:  rdata_o = '0;
            endcase
        end
    end

    AST_DIRECT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || mem_wr_o) && op_field_i != '0 && !is_mirrored(op_field_i)
        |-> mem_addr_o == {bank_sel_i, op_field_i}); // R1
    AST_MIRROR_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || mem_wr_o) && is_mirrored(mem_addr_o[OFF_W-1:0])
        |-> !mem_addr_o[LA_W-1]); // R3
    AST_INDIRECT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || mem_wr_o) && op_field_i == '0 && !is_mirrored(ptr_q[OFF_W-1:0])
        |-> mem_addr_o == ptr_q); // R4
    AST_NO_SELF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || mem_wr_o) |-> mem_addr_o[OFF_W-1:0] != OFF_IND
                                   && mem_addr_o[OFF_W-1:0] != OFF_PTR); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i && !wr_i |-> !mem_rd_o && !mem_wr_o && rdata_o == '0); // R10
endmodule

// File: tb/brfa_addresser_tb_top.sv
// Directed bench for the banked register file addresser.
module brfa_addresser_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] op_field = '0;
    logic       bank_sel = 1'b0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] mem_addr;
    logic       mem_rd;
    logic       mem_wr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;
    logic [7:0] bmem [0:255];
    int         checks = 0;
    int         fails  = 0;

    always #2 clk = ~clk;

    brfa_addresser dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_field_i  (op_field),
        .bank_sel_i  (bank_sel),
        .rd_i        (rd),
        .wr_i        (wr),
        .wdata_i     (wdata),
        .rdata_o     (rdata),
        .mem_addr_o  (mem_addr),
        .mem_rd_o    (mem_rd),
        .mem_wr_o    (mem_wr),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata)
    );

    // Backing array model: combinational read, clocked write
    assign mem_rdata = bmem[mem_addr];
    always @(posedge clk) if (mem_wr) bmem[mem_addr] <= mem_wdata;

    task automatic chk(input bit ok, input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access; checks strobes, address and read data
    task automatic access(input bit bnk, input logic [6:0] fld, input bit r,
                          input bit w, input logic [7:0] wd,
                          input bit exp_strobe, input logic [7:0] exp_addr,
                          input logic [7:0] exp_rd, input string tag);
        @(negedge clk);
        bank_sel = bnk; op_field = fld; rd = r; wr = w; wdata = wd;
        #1;
        if (exp_strobe) begin
            chk(mem_rd == r && mem_wr == w, {tag, " strobe"}, {6'd0, mem_rd, mem_wr}, {6'd0, r, w});
            chk(mem_addr == exp_addr, {tag, " addr"}, mem_addr, exp_addr);
            if (w) chk(mem_wdata == wd, {tag, " wdata"}, mem_wdata, wd);
        end else begin
            chk(!mem_rd && !mem_wr, {tag, " no strobe"}, {6'd0, mem_rd, mem_wr}, 8'h00);
        end
        chk(rdata == exp_rd, {tag, " rdata"}, rdata, exp_rd);
        @(posedge clk); #1;
        rd = 1'b0; wr = 1'b0;
    endtask

    task automatic set_ptr(input bit bnk, input logic [7:0] v);
        access(bnk, 7'h04, 0, 1, v, 0, 8'h00, 8'h00, "R5 ptr write");
    endtask

    task automatic t_reset;
        access(0, 7'h04, 1, 0, 0, 0, 8'h00, 8'h00, "R9 ptr after reset");
        access(1, 7'h00, 1, 0, 0, 0, 8'h00, 8'h00, "R9 indirect after reset");
    endtask

    task automatic t_direct;
        access(0, 7'h05, 0, 1, 8'hA5, 1, 8'h05, 8'h00, "R2 bank0 port");
        access(1, 7'h05, 0, 1, 8'h3C, 1, 8'h85, 8'h00, "R2 bank1 dir");
        access(0, 7'h20, 0, 1, 8'hC3, 1, 8'h20, 8'h00, "R1 gpr write");
        access(1, 7'h01, 0, 1, 8'h9E, 1, 8'h81, 8'h00, "R2 bank1 opt");
        access(0, 7'h05, 1, 0, 0, 1, 8'h05, 8'hA5, "R2 read port");
        access(1, 7'h05, 1, 0, 0, 1, 8'h85, 8'h3C, "R2 read dir");
        access(0, 7'h20, 1, 0, 0, 1, 8'h20, 8'hC3, "R1 gpr read");
        access(0, 7'h01, 1, 0, 0, 1, 8'h01, 8'h00, "R2 bank0 tmr");
    endtask

    task automatic t_mirror;
        access(1, 7'h03, 0, 1, 8'h77, 1, 8'h03, 8'h00, "R3 status b1");
        access(0, 7'h03, 1, 0, 0, 1, 8'h03, 8'h77, "R3 status b0");
        access(1, 7'h0B, 0, 1, 8'h5A, 1, 8'h0B, 8'h00, "R3 ictl b1");
        access(0, 7'h0B, 1, 0, 0, 1, 8'h0B, 8'h5A, "R3 ictl b0");
        access(1, 7'h02, 1, 0, 0, 1, 8'h02, 8'h00, "R3 pcl b1");
    endtask

    task automatic t_pointer;
        set_ptr(1, 8'h20);
        access(0, 7'h04, 1, 0, 0, 0, 8'h00, 8'h20, "R3 R5 ptr read b0");
        access(1, 7'h00, 1, 0, 0, 1, 8'h20, 8'hC3, "R4 indirect b1");
        set_ptr(0, 8'h05);
        access(0, 7'h00, 1, 0, 0, 1, 8'h05, 8'hA5, "R5 back to back");
        set_ptr(0, 8'h85);
        access(0, 7'h00, 1, 0, 0, 1, 8'h85, 8'h3C, "R4 bank bit ignored");
        access(0, 7'h00, 0, 1, 8'h0F, 1, 8'h85, 8'h00, "R4 indirect write");
        access(1, 7'h05, 1, 0, 0, 1, 8'h85, 8'h0F, "R4 readback");
    endtask

    task automatic t_ind_mirror;
        set_ptr(0, 8'h83);
        access(0, 7'h00, 1, 0, 0, 1, 8'h03, 8'h77, "R8 ptr 83");
        set_ptr(0, 8'h8B);
        access(1, 7'h00, 1, 0, 0, 1, 8'h0B, 8'h5A, "R8 ptr 8B");
        set_ptr(0, 8'h84);
        access(0, 7'h00, 1, 0, 0, 0, 8'h00, 8'h84, "R8 ptr 84");
    endtask

    task automatic t_self;
        set_ptr(0, 8'h80);
        access(0, 7'h00, 0, 1, 8'h55, 0, 8'h00, 8'h00, "R6 self write");
        access(0, 7'h00, 1, 0, 0, 0, 8'h00, 8'h00, "R6 self read");
        access(1, 7'h04, 1, 0, 0, 0, 8'h00, 8'h80, "R6 ptr kept");
        set_ptr(1, 8'h00);
        access(1, 7'h00, 1, 0, 0, 0, 8'h00, 8'h00, "R6 ptr 00");
    endtask

    task automatic t_unimpl;
        access(1, 7'h20, 0, 1, 8'h11, 0, 8'h00, 8'h00, "R7 b1 A0 write");
        access(1, 7'h20, 1, 0, 0, 0, 8'h00, 8'h00, "R7 b1 A0 read");
        access(0, 7'h20, 1, 0, 0, 1, 8'h20, 8'hC3, "R7 b0 20 intact");
        access(0, 7'h07, 0, 1, 8'h22, 0, 8'h00, 8'h00, "R7 off 07");
        access(1, 7'h0A, 1, 0, 0, 0, 8'h00, 8'h00, "R7 off 8A");
        access(0, 7'h40, 0, 1, 8'h33, 0, 8'h00, 8'h00, "R7 above gpr");
        access(0, 7'h30, 1, 0, 0, 0, 8'h00, 8'h00, "R7 first unimpl gpr");
        access(0, 7'h2F, 1, 0, 0, 1, 8'h2F, 8'h00, "R1 last gpr");
        set_ptr(0, 8'hA0);
        access(0, 7'h00, 1, 0, 0, 0, 8'h00, 8'h00, "R7 indirect A0");
    endtask

    task automatic t_idle;
        access(0, 7'h05, 0, 0, 8'hFF, 0, 8'h00, 8'h00, "R10 idle");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_direct();
        t_mirror();
        t_pointer();
        t_ind_mirror();
        t_self();
        t_unimpl();
        t_idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 8'h01, 8'h00);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule